// File: doc/BRIEF.md
# Subtract with Borrow and Signed-Underflow Execute Stage

This block is the execute stage for two register-to-register subtract instructions of a 32-bit RISC core with 16-bit instruction words. The first instruction subtracts the source operand and the incoming borrow from the destination operand. The second subtracts without a borrow and reports signed underflow instead. In both cases one status bit, T, carries the flag. For the chained subtract T is both the borrow-in and the borrow-out, so multi-word subtraction can be built from a sequence of these instructions. For the checked subtract T holds the signed underflow indication.

The surrounding pipeline supplies the instruction word with an issue strobe, the two register values the word selects, and the current T. One clock edge later the block presents the difference, the destination register index with a write enable, and the next value of T. Any word that matches neither encoding raises an illegal-opcode flag and leaves the register file and T untouched.

Top module: `subx_exec`

## Requirements
- R1: An issued word with bits [15:12]=4'b0011 and bits [3:0]=4'b1010 is the chained subtract. It asserts wr_en_o and puts bits [11:8] on rd_idx_o. Bits [7:4] name the source register, whose value arrives on rm_val_i.
- R2: The chained subtract writes rn_val_i − rm_val_i − t_i, modulo 2^32, to result_o.
- R3: After the chained subtract, t_o is 1 exactly when the unsigned value of rn_val_i is less than rm_val_i + t_i.
- R4: An issued word with bits [15:12]=4'b0011 and bits [3:0]=4'b1011 is the checked subtract. It asserts wr_en_o, puts bits [11:8] on rd_idx_o, and writes rn_val_i − rm_val_i, modulo 2^32, to result_o.
- R5: After the checked subtract, t_o is 1 exactly when the two's-complement difference of rn_val_i and rm_val_i falls outside the 32-bit signed range. Otherwise t_o is 0.
- R6: Any other issued word sets illegal_o to 1, sets wr_en_o to 0, and makes t_o equal to t_i.
- R7: Each output reflects the inputs sampled at the previous rising edge of clk_i. There is exactly one cycle of latency and no stall.
- R8: While rst_ni is low, wr_en_o, illegal_o, t_o, rd_idx_o and result_o are all 0.
- R9: A cycle with issue_i low gives wr_en_o=0, illegal_o=0 and t_o=t_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 16 | Instruction word |
| rn_val_i | input | 32 | Value of the destination/minuend register |
| rm_val_i | input | 32 | Value of the source/subtrahend register |
| t_i | input | 1 | Current T status bit |
| result_o | output | 32 | Difference to write back |
| rd_idx_o | output | 4 | Destination register index |
| wr_en_o | output | 1 | Register write enable |
| t_o | output | 1 | Next T status bit |
| illegal_o | output | 1 | Issued word is not a supported subtract |

## Verification
The hardest cases to reach are the two boundaries where the flag is decided by a single unit of difference. For the chained subtract, the borrow-in alone turns equal operands into a borrow, for example 0 − 0 − 1 and all-ones − all-ones − 1. For the checked subtract, the signed difference lands exactly on or one step beyond the signed limits. Random operands almost never land on these boundaries, so the stimulus first runs directed operand pairs at the sign-bit and all-ones edges, including near-miss opcodes that differ from a legal encoding in one nibble. It then runs a random phase whose operands are biased toward equal values and the extreme values.

// File: rtl/subx_pkg.sv
package subx_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_SUBC = 2'd1,
    OP_SUBV = 2'd2,
    OP_ILL  = 2'd3
  } subx_op_e;

  localparam logic [3:0] GRP_ARITH = 4'b0011;
  localparam logic [3:0] FN_SUBC   = 4'b1010;
  localparam logic [3:0] FN_SUBV   = 4'b1011;
endpackage

// File: rtl/subx_decode.sv
module subx_decode
  import subx_pkg::*;
#(
  parameter int ILEN  = 16,
  parameter int IDX_W = 4
) (
  input  logic             issue_i,
  input  logic [ILEN-1:0]  instr_i,
  output subx_op_e         op_o,
  output logic [IDX_W-1:0] rn_o,
  output logic [IDX_W-1:0] rm_o
);
  localparam int GRP_LSB = ILEN - 4;
  localparam int RN_LSB  = GRP_LSB - IDX_W;
  localparam int RM_LSB  = RN_LSB - IDX_W;

  logic [3:0] grp, fn;

  assign grp  = instr_i[ILEN-1:GRP_LSB];
  assign fn   = instr_i[3:0];
  assign rn_o = instr_i[RN_LSB +: IDX_W];
  assign rm_o = instr_i[RM_LSB +: IDX_W];

  always_comb begin
    if (!issue_i)                              op_o = OP_NONE;
    else if (grp == GRP_ARITH && fn == FN_SUBC) op_o = OP_SUBC;
    else if (grp == GRP_ARITH && fn == FN_SUBV) op_o = OP_SUBV;
    else                                        op_o = OP_ILL;
  end
endmodule

// File: rtl/subx_sub.sv
module subx_sub #(
  parameter int XLEN   = 32,
  parameter bit RIPPLE = 1'b0
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            bin_i,
  output logic [XLEN-1:0] diff_o,
  output logic            bout_o
);
  generate
    if (RIPPLE) begin : g_ripple
      logic [XLEN:0] bw;
      assign bw[0] = bin_i;
      for (genvar i = 0; i < XLEN; i++) begin : g_bit
        assign diff_o[i] = a_i[i] ^ b_i[i] ^ bw[i];
        assign bw[i+1]   = (~a_i[i] & b_i[i]) | (~(a_i[i] ^ b_i[i]) & bw[i]);
      end
      assign bout_o = bw[XLEN];
    end else begin : g_flat
      logic [XLEN:0] wide;
      assign wide   = {1'b0, a_i} - {1'b0, b_i} - {{XLEN{1'b0}}, bin_i};
      assign diff_o = wide[XLEN-1:0];
      assign bout_o = wide[XLEN];
    end
  endgenerate
endmodule

// File: rtl/subx_flag.sv
module subx_flag
  import subx_pkg::*;
(
  input  subx_op_e op_i,
  input  logic     a_msb_i,
  input  logic     b_msb_i,
  input  logic     d_msb_i,
  input  logic     borrow_i,
  input  logic     t_i,
  output logic     t_next_o
);
  logic sgn_ovf;
  // operands of opposite sign and result sign flipped away from minuend
  assign sgn_ovf = (a_msb_i ^ b_msb_i) & (d_msb_i ^ a_msb_i);

  always_comb begin
    unique case (op_i)
      OP_SUBC: t_next_o = borrow_i;
      OP_SUBV: t_next_o = sgn_ovf;
      default: t_next_o = t_i;
    endcase
  end
endmodule

// File: rtl/subx_exec.sv
module subx_exec
  import subx_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int ILEN   = 16,
  parameter int IDX_W  = 4,
  parameter bit RIPPLE = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic [ILEN-1:0]  instr_i,
  input  logic [XLEN-1:0]  rn_val_i,
  input  logic [XLEN-1:0]  rm_val_i,
  input  logic             t_i,
  output logic [XLEN-1:0]  result_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             wr_en_o,
  output logic             t_o,
  output logic             illegal_o
);
  localparam int MSB = XLEN - 1;

  subx_op_e         op;
  logic [IDX_W-1:0] rn_idx, rm_idx;
  logic [XLEN-1:0]  diff;
  logic             bout, bin, t_next, legal;

  subx_decode #(.ILEN(ILEN), .IDX_W(IDX_W)) u_dec (
    .issue_i (issue_i),
    .instr_i (instr_i),
    .op_o    (op),
    .rn_o    (rn_idx),
    .rm_o    (rm_idx)
  );

  // checked subtract runs the same datapath with borrow-in forced low
  assign bin = (op == OP_SUBC) ? t_i : 1'b0;

  subx_sub #(.XLEN(XLEN), .RIPPLE(RIPPLE)) u_sub (
    .a_i    (rn_val_i),
    .b_i    (rm_val_i),
    .bin_i  (bin),
    .diff_o (diff),
    .bout_o (bout)
  );

  subx_flag u_flag (
    .op_i     (op),
    .a_msb_i  (rn_val_i[MSB]),
    .b_msb_i  (rm_val_i[MSB]),
    .d_msb_i  (diff[MSB]),
    .borrow_i (bout),
    .t_i      (t_i),
    .t_next_o (t_next)
  );

  assign legal = (op == OP_SUBC) || (op == OP_SUBV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      rd_idx_o  <= '0;
      wr_en_o   <= 1'b0;
      t_o       <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      wr_en_o   <= legal;
      illegal_o <= (op == OP_ILL);
      t_o       <= t_next;
      if (legal) begin
        result_o <= diff;
        rd_idx_o <= rn_idx;
      end
    end
  end

  // R1: a write only follows an issued legal word
  a_r1_write_needs_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (!illegal_o && $past(issue_i)));

  // R3: minuend + borrow-out*2^XLEN == result + subtrahend + borrow-in
  a_r3_borrow_chain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(op == OP_SUBC) |->
      (({2'b0, result_o} + {2'b0, $past(rm_val_i)} + {{(XLEN+1){1'b0}}, $past(t_i)})
       == ({2'b0, $past(rn_val_i)} + {1'b0, t_o, {XLEN{1'b0}}})));

  // R5: underflow flag only with opposite operand signs and a flipped result sign
  a_r5_underflow_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(op == OP_SUBV) && t_o) |->
      (($past(rn_val_i[MSB]) != $past(rm_val_i[MSB])) &&
       (result_o[MSB] != $past(rn_val_i[MSB]))));

  // R6: illegal word leaves T and the register file alone
  a_r6_illegal_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(op == OP_ILL) |-> (illegal_o && !wr_en_o && (t_o == $past(t_i))));

  // R9: idle cycle passes T through
  a_r9_idle_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!issue_i) |-> (!illegal_o && !wr_en_o && (t_o == $past(t_i))));
endmodule

// File: tb/subx_exec_tb.sv
module subx_exec_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        issue_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic [31:0] rn_val_i = '0;
  logic [31:0] rm_val_i = '0;
  logic        t_i = 1'b0;
  logic [31:0] result_o;
  logic [3:0]  rd_idx_o;
  logic        wr_en_o, t_o, illegal_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  subx_exec u_dut (
    .clk_i, .rst_ni, .issue_i, .instr_i, .rn_val_i, .rm_val_i, .t_i,
    .result_o, .rd_idx_o, .wr_en_o, .t_o, .illegal_o
  );

  typedef struct {
    bit        wr;
    bit        ill;
    bit        t;
    bit [3:0]  rd;
    bit [31:0] res;
    string     tag;
  } exp_t;

  exp_t q[$];

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic exp_t model(bit iss, bit [15:0] w, bit [31:0] rn, bit [31:0] rm, bit t);
    exp_t e;
    longint sd;
    e.wr = 0; e.ill = 0; e.t = t; e.rd = 0; e.res = 0; e.tag = "R9";
    if (!iss) return e;
    if (w[15:12] == 4'h3 && w[3:0] == 4'hA) begin
      e.wr = 1; e.rd = w[11:8]; e.tag = "R2/R3";
      e.res = rn - rm - 32'(t);
      e.t = (longint'(rn) < longint'(rm) + longint'(t));
    end else if (w[15:12] == 4'h3 && w[3:0] == 4'hB) begin
      e.wr = 1; e.rd = w[11:8]; e.tag = "R4/R5";
      e.res = rn - rm;
      sd = longint'($signed(rn)) - longint'($signed(rm));
      e.t = (sd > 64'sd2147483647) || (sd < -64'sd2147483648);
    end else begin
      e.ill = 1; e.tag = "R6";
    end
    return e;
  endfunction

  task automatic compare_head();
    exp_t e;
    if (q.size() == 0) return;
    e = q.pop_front();
    chk({e.tag, " R7 wr_en"}, wr_en_o, e.wr);
    chk({e.tag, " R6 illegal"}, illegal_o, e.ill);
    chk({e.tag, " T"}, t_o, e.t);
    if (e.wr) begin
      chk({e.tag, " R1 rd_idx"}, rd_idx_o, e.rd);
      chk({e.tag, " result"}, result_o, e.res);
    end
  endtask

  task automatic step(input bit iss, input bit [15:0] w, input bit [31:0] rn,
                      input bit [31:0] rm, input bit t);
    @(negedge clk_i);
    compare_head();
    issue_i = iss; instr_i = w; rn_val_i = rn; rm_val_i = rm; t_i = t;
    q.push_back(model(iss, w, rn, rm, t));
  endtask

  function automatic bit [31:0] pick();
    case ($urandom_range(0, 5))
      0: return 32'h0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h7FFF_FFFF;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    bit [31:0] a;
    bit [15:0] w;
    repeat (3) @(negedge clk_i);
    // R8: reset state
    chk("R8 wr_en", wr_en_o, 0);
    chk("R8 illegal", illegal_o, 0);
    chk("R8 t", t_o, 0);
    chk("R8 rd_idx", rd_idx_o, 0);
    chk("R8 result", result_o, 0);
    rst_ni = 1'b1;

    // R2 R3 borrow corners
    step(1, 16'h35_6A, 32'h0, 32'h0, 1);
    step(1, 16'h3F_0A, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1);
    step(1, 16'h31_2A, 32'h5, 32'h4, 1);
    step(1, 16'h30_0A, 32'h5, 32'h5, 0);
    step(1, 16'h3A_BA, 32'h0, 32'hFFFF_FFFF, 0);
    // R4 R5 signed limits
    step(1, 16'h32_1B, 32'h8000_0000, 32'h1, 0);
    step(1, 16'h32_1B, 32'h8000_0001, 32'h1, 1);
    step(1, 16'h3E_DB, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0);
    step(1, 16'h3E_DB, 32'h7FFF_FFFE, 32'hFFFF_FFFF, 1);
    step(1, 16'h34_4B, 32'h0, 32'h8000_0000, 0);
    // R6 near-miss opcodes, T kept at both values
    step(1, 16'h23_4A, 32'h1, 32'h2, 1);
    step(1, 16'h33_4C, 32'h1, 32'h2, 0);
    step(1, 16'h33_49, 32'h1, 32'h2, 1);
    step(1, 16'h73_4B, 32'h1, 32'h2, 0);
    // R9 idle with legal-looking word
    step(0, 16'h31_2A, 32'h0, 32'h1, 1);
    step(0, 16'h31_2B, 32'h8000_0000, 32'h1, 0);
    // chained multi-word: borrow flows through T (R3)
    step(1, 16'h31_2A, 32'h0, 32'h1, 0);
    step(1, 16'h33_4A, 32'h0, 32'h0, 1);

    for (int i = 0; i < 3000; i++) begin
      a = pick();
      case ($urandom_range(0, 3))
        0: w = {4'h3, 4'($urandom()), 4'($urandom()), 4'hA};
        1: w = {4'h3, 4'($urandom()), 4'($urandom()), 4'hB};
        default: w = 16'($urandom());
      endcase
      step($urandom_range(0, 7) != 0, w, a,
           ($urandom_range(0, 3) == 0) ? a : pick(), 1'($urandom()));
    end
    step(0, 16'h0, 32'h0, 32'h0, 0);
    @(negedge clk_i);
    compare_head();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule